// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical page number when a translation cache misses. It takes one request at a time and walks a two-level table held in memory: a directory indexed by the top ten address bits, then a table indexed by the next ten. It reaches that memory through a simple valid/ready port that reads or writes one 32-bit word. The directory step can end early on a 4 MB large page. On a hit the walker reports the 4 KB physical page number, whether writes may be cached, and whether the mapping came from a large page. A failed walk reports a page fault with the linear address and a three-bit error code.

While it walks, the walker keeps the accessed and dirty flags in memory up to date. It combines the user and write rights of the directory and the table entry, and honours the supervisor write-protect switch. Write permission is handed out only for pages whose final entry is already marked dirty, so a later first write to a clean page comes back for another walk. Translation control is sampled when a request is accepted: the paging enable, the write-protect switch, the directory base, the large-page enable and the address-line mask.

Top module: `ptw2_walker`

## Requirements
- R1: With paging disabled at acceptance, no memory access is made. The response has no fault, page number = (linear address AND address mask) bits 31:12, write allowed, and large-page flag 0.
- R2: The directory entry is read at ((base with bits 11:0 cleared) + linear bits 31:22 × 4) AND the address mask.
- R3: A directory or table entry whose bit 0 (present) is 0 ends the walk in a fault with error bit 0 = 0 and no further memory access.
- R4: If directory entry bit 7 is set and the large-page enable is 1, no table entry is read. The page number is {(entry AND mask) bits 31:22, linear bits 21:12} and the large-page flag is 1. If the enable is 0, bit 7 is ignored and a normal two-level walk follows.
- R5: On a 4 KB walk, a directory entry with bit 5 (accessed) clear is first written back with bit 5 set. The table entry is then read at ((directory entry bits 31:12 followed by 12 zeros) + linear bits 21:12 × 4) AND mask.
- R6: Effective rights are the AND of the directory and table bits 2 (user) and 1 (write). A user access faults if the user bit is 0, or if it writes and the write bit is 0. A supervisor write faults on write bit 0 only when write-protect is on. A rights fault has error bit 0 = 1.
- R7: After a successful check, the final entry is written back with bit 5 set, and with bit 6 (dirty) set as well for a write. The write is skipped when those bits already hold.
- R8: Write is granted only when the final entry, after write-back, has bit 6 set and either the effective write bit is 1 or the access is a supervisor access with write-protect off.
- R9: A fault response returns the requesting linear address, with error bit 1 = write request and bit 2 = user request.
- R10: req_ready is high only while idle. A memory request holds its address, direction and data until mem_ready. rsp_valid is a single-cycle pulse per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken this cycle |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | Request is a write access |
| req_user | input | 1 | Request is a user-level access |
| cfg_paging | input | 1 | Paging enable |
| cfg_wp | input | 1 | Supervisor write-protect enable |
| cfg_root | input | 32 | Directory base address |
| cfg_large_en | input | 1 | Large-page enable |
| cfg_a20_mask | input | 32 | Mask applied to every physical address |
| mem_valid | output | 1 | Memory access requested |
| mem_ready | input | 1 | Memory access completes this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_rdata | input | 32 | Entry value read, valid with mem_ready |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 1 | Walk ended in a page fault |
| rsp_ppn | output | 20 | Physical 4 KB page number |
| rsp_writable | output | 1 | Write may be cached for this page |
| rsp_large | output | 1 | Mapping came from a large page |
| rsp_fault_addr | output | 32 | Faulting linear address |
| rsp_err | output | 3 | Fault code: bit0 rights, bit1 write, bit2 user |

## Verification
A wrong walk state shows up at the memory port on the very next handshake. The bench's model predicts the exact order of reads and write-backs, so a skipped accessed-bit update, a missing table read or an extra write is caught at the cycle where the access is granted. Wrong rights or page-number logic is caught on the single response pulse that ends the request. A stuck state machine shows up as a missing pulse within a few hundred cycles.

// File: rtl/ptw2_pkg.sv
package ptw2_pkg;
   // entry flag positions, decoded by the table format in memory
   localparam int ENT_P  = 0;
   localparam int ENT_RW = 1;
   localparam int ENT_US = 2;
   localparam int ENT_A  = 5;
   localparam int ENT_D  = 6;
   localparam int ENT_PS = 7;
   // fault code positions
   localparam int ERR_PROT = 0;
   localparam int ERR_WR   = 1;
   localparam int ERR_USR  = 2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_DIR,
      ST_WB_DIR,
      ST_RD_TBL,
      ST_WB_TBL,
      ST_DONE,
      ST_FAULT
   } walk_state_e;
endpackage

// File: rtl/ptw2_addr.sv
module ptw2_addr #(
   parameter int ADDR_W      = 32,
   parameter int PAGE_SHIFT  = 12,
   parameter int ENTRY_SHIFT = 2
) (
   input  logic [ADDR_W-PAGE_SHIFT-1:0] root_frame,
   input  logic [ADDR_W-PAGE_SHIFT-1:0] dir_frame,
   input  logic [ADDR_W-PAGE_SHIFT-1:0] vpn,
   input  logic [ADDR_W-1:0]            a20_mask,
   output logic [ADDR_W-1:0]            dir_addr,
   output logic [ADDR_W-1:0]            tbl_addr
);
   localparam int PPN_W = ADDR_W - PAGE_SHIFT;
   localparam int IDX_W = PPN_W / 2;

   logic [IDX_W-1:0] dir_index;
   logic [IDX_W-1:0] tbl_index;

   always_comb begin
      dir_index = vpn[PPN_W-1 -: IDX_W];
      tbl_index = vpn[IDX_W-1:0];
      dir_addr  = ({root_frame, {PAGE_SHIFT{1'b0}}}
                   + (ADDR_W'(dir_index) << ENTRY_SHIFT)) & a20_mask;
      tbl_addr  = ({dir_frame, {PAGE_SHIFT{1'b0}}}
                   + (ADDR_W'(tbl_index) << ENTRY_SHIFT)) & a20_mask;
   end
endmodule

// File: rtl/ptw2_perm.sv
module ptw2_perm
   import ptw2_pkg::*;
#(
   parameter int ENT_W = 32
) (
   input  logic [ENT_W-1:0] dir_ent,
   input  logic [ENT_W-1:0] tbl_ent,
   input  logic             is_large,
   input  logic             is_write,
   input  logic             is_user,
   input  logic             wp_on,
   output logic             violation,
   output logic             need_wb,
   output logic             writable,
   output logic [ENT_W-1:0] final_ent
);
   logic             eff_rw;
   logic             eff_us;
   logic [ENT_W-1:0] base_ent;

   always_comb begin
      eff_rw   = is_large ? dir_ent[ENT_RW] : (dir_ent[ENT_RW] & tbl_ent[ENT_RW]);
      eff_us   = is_large ? dir_ent[ENT_US] : (dir_ent[ENT_US] & tbl_ent[ENT_US]);
      base_ent = is_large ? dir_ent : tbl_ent;

      if (is_user)
         violation = !eff_us || (is_write && !eff_rw);
      else
         violation = wp_on && is_write && !eff_rw;

      final_ent        = base_ent;
      final_ent[ENT_A] = 1'b1;
      if (is_write)
         final_ent[ENT_D] = 1'b1;
      need_wb  = (final_ent != base_ent);
      writable = final_ent[ENT_D] && (eff_rw || (!is_user && !wp_on));
   end
endmodule

// File: rtl/ptw2_walker.sv
module ptw2_walker
   import ptw2_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int PAGE_SHIFT  = 12,
   parameter int ENTRY_SHIFT = 2,
   parameter bit LARGE_PAGES = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   output logic                         req_ready,
   input  logic [ADDR_W-1:0]            req_vaddr,
   input  logic                         req_write,
   input  logic                         req_user,
   input  logic                         cfg_paging,
   input  logic                         cfg_wp,
   input  logic [ADDR_W-1:0]            cfg_root,
   input  logic                         cfg_large_en,
   input  logic [ADDR_W-1:0]            cfg_a20_mask,
   output logic                         mem_valid,
   input  logic                         mem_ready,
   output logic                         mem_we,
   output logic [ADDR_W-1:0]            mem_addr,
   output logic [ADDR_W-1:0]            mem_wdata,
   input  logic [ADDR_W-1:0]            mem_rdata,
   output logic                         rsp_valid,
   output logic                         rsp_fault,
   output logic [ADDR_W-PAGE_SHIFT-1:0] rsp_ppn,
   output logic                         rsp_writable,
   output logic                         rsp_large,
   output logic [ADDR_W-1:0]            rsp_fault_addr,
   output logic [2:0]                   rsp_err
);
   localparam int PPN_W       = ADDR_W - PAGE_SHIFT;
   localparam int IDX_W       = PPN_W / 2;
   localparam int LARGE_SHIFT = PAGE_SHIFT + IDX_W;

   initial begin
      if ((PPN_W % 2) != 0)
         $error("page number width must split into two equal indices");
      if (PAGE_SHIFT < ENTRY_SHIFT + IDX_W)
         $error("one table must fit inside one page");
      if (PAGE_SHIFT <= ENT_PS)
         $error("entry flags must lie below the frame field");
   end

   walk_state_e      state_q;
   logic [ADDR_W-1:0] va_q, pde_q, pte_q, a20_q;
   logic [PPN_W-1:0]  root_q, ppn_q;
   logic              wr_q, usr_q, wp_q, pse_q, large_q, wrok_q;
   logic [2:0]        err_q;

   logic [ADDR_W-1:0] dir_addr, tbl_addr, perm_dir, final_ent;
   logic [PPN_W-1:0]  rdata_frame, bypass_frame;
   logic              large_now, violation, need_wb, writable, handshake;

   // large-page decode variant chosen at elaboration
   generate
      if (LARGE_PAGES) begin : g_large
         assign large_now = mem_rdata[ENT_PS] & pse_q;
      end else begin : g_small
         assign large_now = 1'b0 & pse_q & mem_rdata[ENT_PS];
      end
   endgenerate

   ptw2_addr #(
      .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .ENTRY_SHIFT(ENTRY_SHIFT)
   ) u_addr (
      .root_frame (root_q),
      .dir_frame  (pde_q[ADDR_W-1:PAGE_SHIFT]),
      .vpn        (va_q[ADDR_W-1:PAGE_SHIFT]),
      .a20_mask   (a20_q),
      .dir_addr   (dir_addr),
      .tbl_addr   (tbl_addr)
   );

   assign perm_dir = (state_q == ST_RD_DIR) ? mem_rdata : pde_q;

   ptw2_perm #(.ENT_W(ADDR_W)) u_perm (
      .dir_ent   (perm_dir),
      .tbl_ent   (mem_rdata),
      .is_large  (state_q == ST_RD_DIR),
      .is_write  (wr_q),
      .is_user   (usr_q),
      .wp_on     (wp_q),
      .violation (violation),
      .need_wb   (need_wb),
      .writable  (writable),
      .final_ent (final_ent)
   );

   assign rdata_frame  = mem_rdata[ADDR_W-1:PAGE_SHIFT] & a20_q[ADDR_W-1:PAGE_SHIFT];
   assign bypass_frame = req_vaddr[ADDR_W-1:PAGE_SHIFT] & cfg_a20_mask[ADDR_W-1:PAGE_SHIFT];
   assign handshake    = mem_valid && mem_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         va_q    <= '0;
         pde_q   <= '0;
         pte_q   <= '0;
         a20_q   <= '0;
         root_q  <= '0;
         ppn_q   <= '0;
         wr_q    <= 1'b0;
         usr_q   <= 1'b0;
         wp_q    <= 1'b0;
         pse_q   <= 1'b0;
         large_q <= 1'b0;
         wrok_q  <= 1'b0;
         err_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (req_valid) begin
               va_q    <= req_vaddr;
               wr_q    <= req_write;
               usr_q   <= req_user;
               wp_q    <= cfg_wp;
               pse_q   <= cfg_large_en;
               root_q  <= cfg_root[ADDR_W-1:PAGE_SHIFT];
               a20_q   <= cfg_a20_mask;
               err_q   <= '0;
               large_q <= 1'b0;
               if (!cfg_paging) begin
                  ppn_q   <= bypass_frame;
                  wrok_q  <= 1'b1;
                  state_q <= ST_DONE;
               end else begin
                  state_q <= ST_RD_DIR;
               end
            end
            ST_RD_DIR: if (handshake) begin
               pde_q <= mem_rdata;
               if (!mem_rdata[ENT_P]) begin
                  err_q   <= {usr_q, wr_q, 1'b0};
                  state_q <= ST_FAULT;
               end else if (large_now) begin
                  large_q <= 1'b1;
                  if (violation) begin
                     err_q   <= {usr_q, wr_q, 1'b1};
                     state_q <= ST_FAULT;
                  end else begin
                     ppn_q   <= {rdata_frame[PPN_W-1:IDX_W], va_q[LARGE_SHIFT-1:PAGE_SHIFT]};
                     wrok_q  <= writable;
                     pde_q   <= final_ent;
                     state_q <= need_wb ? ST_WB_DIR : ST_DONE;
                  end
               end else if (!mem_rdata[ENT_A]) begin
                  pde_q[ENT_A] <= 1'b1;
                  state_q      <= ST_WB_DIR;
               end else begin
                  state_q <= ST_RD_TBL;
               end
            end
            ST_WB_DIR: if (handshake)
               state_q <= large_q ? ST_DONE : ST_RD_TBL;
            ST_RD_TBL: if (handshake) begin
               if (!mem_rdata[ENT_P]) begin
                  err_q   <= {usr_q, wr_q, 1'b0};
                  state_q <= ST_FAULT;
               end else if (violation) begin
                  err_q   <= {usr_q, wr_q, 1'b1};
                  state_q <= ST_FAULT;
               end else begin
                  ppn_q   <= rdata_frame;
                  wrok_q  <= writable;
                  pte_q   <= final_ent;
                  state_q <= need_wb ? ST_WB_TBL : ST_DONE;
               end
            end
            ST_WB_TBL: if (handshake)
               state_q <= ST_DONE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      req_ready      = (state_q == ST_IDLE);
      mem_valid      = (state_q == ST_RD_DIR) || (state_q == ST_WB_DIR)
                    || (state_q == ST_RD_TBL) || (state_q == ST_WB_TBL);
      mem_we         = (state_q == ST_WB_DIR) || (state_q == ST_WB_TBL);
      mem_addr       = ((state_q == ST_RD_DIR) || (state_q == ST_WB_DIR)) ? dir_addr : tbl_addr;
      mem_wdata      = (state_q == ST_WB_DIR) ? pde_q : pte_q;
      rsp_valid      = (state_q == ST_DONE) || (state_q == ST_FAULT);
      rsp_fault      = (state_q == ST_FAULT);
      rsp_ppn        = ppn_q;
      rsp_writable   = wrok_q;
      rsp_large      = large_q;
      rsp_fault_addr = va_q;
      rsp_err        = err_q;
   end
endmodule

// File: rtl/ptw2_check.sv
module ptw2_check
   import ptw2_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_vaddr,
   input logic              req_write,
   input logic              req_user,
   input logic              cfg_paging,
   input logic              mem_valid,
   input logic              mem_ready,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [ADDR_W-1:0] mem_wdata,
   input logic              rsp_valid,
   input logic              rsp_fault,
   input logic              rsp_writable,
   input logic              rsp_large,
   input logic [ADDR_W-1:0] rsp_fault_addr,
   input logic [2:0]        rsp_err
);
   logic              pg_seen, wr_seen, usr_seen;
   logic [ADDR_W-1:0] va_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pg_seen  <= 1'b0;
         wr_seen  <= 1'b0;
         usr_seen <= 1'b0;
         va_seen  <= '0;
      end else if (req_valid && req_ready) begin
         pg_seen  <= cfg_paging;
         wr_seen  <= req_write;
         usr_seen <= req_user;
         va_seen  <= req_vaddr;
      end
   end

   AST_BYPASS_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> pg_seen); // R1
   AST_BYPASS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !pg_seen) |-> (!rsp_fault && rsp_writable && !rsp_large)); // R1
   AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_we) |-> mem_wdata[ENT_A]); // R7
   AST_FAULT_INFO: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_fault_addr == va_seen && rsp_err[ERR_WR] == wr_seen
                                    && rsp_err[ERR_USR] == usr_seen)); // R9
   AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid || rsp_valid) |-> !req_ready); // R10
   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)
                                     && $stable(mem_wdata))); // R10
   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R10
endmodule

bind ptw2_walker ptw2_check #(.ADDR_W(ADDR_W)) u_check (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
   .cfg_paging(cfg_paging), .mem_valid(mem_valid), .mem_ready(mem_ready),
   .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
   .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_writable(rsp_writable),
   .rsp_large(rsp_large), .rsp_fault_addr(rsp_fault_addr), .rsp_err(rsp_err)
);

// File: tb/tb_ptw2_walker.sv
module tb_ptw2_walker;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        cfg_paging = 1'b0, cfg_wp = 1'b0, cfg_large_en = 1'b0;
   logic [31:0] cfg_root = '0, cfg_a20_mask = '1;
   logic        mem_ready = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        req_ready, mem_valid, mem_we, rsp_valid, rsp_fault, rsp_writable, rsp_large;
   logic [31:0] mem_addr, mem_wdata, rsp_fault_addr;
   logic [19:0] rsp_ppn;
   logic [2:0]  rsp_err;

   ptw2_walker dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
      .cfg_paging(cfg_paging), .cfg_wp(cfg_wp), .cfg_root(cfg_root),
      .cfg_large_en(cfg_large_en), .cfg_a20_mask(cfg_a20_mask),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_ppn(rsp_ppn),
      .rsp_writable(rsp_writable), .rsp_large(rsp_large),
      .rsp_fault_addr(rsp_fault_addr), .rsp_err(rsp_err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit [31:0] mem [bit [31:0]];
   bit        exp_we[$];
   bit [31:0] exp_addr[$];
   bit [31:0] exp_data[$];
   bit        exp_pending = 1'b0;
   bit        e_fault, e_wr, e_large;
   bit [19:0] e_ppn;
   bit [2:0]  e_err;
   bit [31:0] e_va;
   string     cur_tag = "R10";
   int        wait_cnt = 0;
   int        grants = 0;

   task automatic chk(bit ok, string tag, string what, bit [31:0] act, bit [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic bit [31:0] rd(bit [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   function automatic bit rights_bad(bit [31:0] eff, bit w, bit u, bit wp);
      if (u) return !eff[2] || (w && !eff[1]);
      return wp && w && !eff[1];
   endfunction

   // behavioural reference: expected access list and response
   task automatic model(bit [31:0] va, bit w, bit u, bit pg, bit wp,
                        bit [31:0] root, bit pse, bit [31:0] a20);
      bit [31:0] pa, pde, ta, pte, eff, nw;
      exp_we.delete(); exp_addr.delete(); exp_data.delete();
      e_fault = 0; e_wr = 0; e_large = 0; e_ppn = 0; e_err = 0; e_va = va;
      if (!pg) begin
         e_ppn = 20'((va & a20) >> 12); e_wr = 1; return;
      end
      pa = ((root & ~32'hfff) + ((va >> 22) << 2)) & a20;
      exp_we.push_back(0); exp_addr.push_back(pa); exp_data.push_back(0);
      pde = rd(pa);
      if (!pde[0]) begin e_fault = 1; e_err = {u, w, 1'b0}; return; end
      if (pde[7] && pse) begin
         e_large = 1;
         if (rights_bad(pde, w, u, wp)) begin e_fault = 1; e_err = {u, w, 1'b1}; return; end
         nw = pde | 32'h20 | (w ? 32'h40 : 32'h0);
         if (nw != pde) begin exp_we.push_back(1); exp_addr.push_back(pa); exp_data.push_back(nw); end
         e_wr = nw[6] && (pde[1] || (!u && !wp));
         e_ppn = 20'((((pde & a20) >> 22) << 10) | ((va >> 12) & 32'h3ff));
         return;
      end
      if (!pde[5]) begin
         pde = pde | 32'h20;
         exp_we.push_back(1); exp_addr.push_back(pa); exp_data.push_back(pde);
      end
      ta = ((pde & ~32'hfff) + (((va >> 12) & 32'h3ff) << 2)) & a20;
      exp_we.push_back(0); exp_addr.push_back(ta); exp_data.push_back(0);
      pte = rd(ta);
      if (!pte[0]) begin e_fault = 1; e_err = {u, w, 1'b0}; return; end
      eff = pte & pde;
      if (rights_bad(eff, w, u, wp)) begin e_fault = 1; e_err = {u, w, 1'b1}; return; end
      nw = pte | 32'h20 | (w ? 32'h40 : 32'h0);
      if (nw != pte) begin exp_we.push_back(1); exp_addr.push_back(ta); exp_data.push_back(nw); end
      e_wr = nw[6] && (eff[1] || (!u && !wp));
      e_ppn = 20'((pte & a20) >> 12);
   endtask

   // memory responder and per-clock comparison against the model
   always @(negedge clk) begin
      mem_ready = 1'b0;
      if (rst_n && mem_valid) begin
         if (wait_cnt == 0) begin
            mem_ready = 1'b1;
            mem_rdata = rd(mem_addr);
            if (exp_addr.size() == 0) begin
               chk(0, "R10", "unexpected memory access", mem_addr, 32'h0);
            end else begin
               chk(mem_we == exp_we[0], cur_tag, "access direction", 32'(mem_we), 32'(exp_we[0]));
               chk(mem_addr == exp_addr[0], cur_tag, "access address", mem_addr, exp_addr[0]);
               if (exp_we[0])
                  chk(mem_wdata == exp_data[0], "R7", "write-back data", mem_wdata, exp_data[0]);
               void'(exp_we.pop_front()); void'(exp_addr.pop_front()); void'(exp_data.pop_front());
            end
            if (mem_we) mem[mem_addr] = mem_wdata;
            grants++;
            wait_cnt = grants % 3;
         end else begin
            wait_cnt--;
         end
      end
      if (rst_n && rsp_valid) begin
         if (!exp_pending) begin
            chk(0, "R10", "unexpected response", 32'(rsp_valid), 32'h0);
         end else begin
            chk(exp_addr.size() == 0, cur_tag, "accesses left at response", 32'(exp_addr.size()), 32'h0);
            chk(rsp_fault == e_fault, cur_tag, "fault flag", 32'(rsp_fault), 32'(e_fault));
            if (e_fault) begin
               chk(rsp_err == e_err, "R9", "error code", 32'(rsp_err), 32'(e_err));
               chk(rsp_fault_addr == e_va, "R9", "fault address", rsp_fault_addr, e_va);
            end else begin
               chk(rsp_ppn == e_ppn, cur_tag, "page number", 32'(rsp_ppn), 32'(e_ppn));
               chk(rsp_writable == e_wr, "R8", "write grant", 32'(rsp_writable), 32'(e_wr));
               chk(rsp_large == e_large, cur_tag, "large flag", 32'(rsp_large), 32'(e_large));
            end
            exp_pending = 1'b0;
         end
      end
   end

   task automatic run(string tag, bit [31:0] va, bit w, bit u, bit pg, bit wp,
                      bit [31:0] root, bit pse, bit [31:0] a20);
      int n = 0;
      @(negedge clk);
      cfg_paging = pg; cfg_wp = wp; cfg_root = root; cfg_large_en = pse; cfg_a20_mask = a20;
      model(va, w, u, pg, wp, root, pse, a20);
      cur_tag = tag;
      exp_pending = 1'b1;
      chk(req_ready == 1'b1, "R10", "ready while idle", 32'(req_ready), 32'h1);
      req_valid = 1'b1; req_vaddr = va; req_write = w; req_user = u;
      @(negedge clk);
      req_valid = 1'b0;
      while (exp_pending && n < 500) begin
         @(negedge clk);
         n++;
      end
      if (exp_pending) begin
         chk(0, tag, "response timeout", 32'(n), 32'd500);
         exp_pending = 1'b0;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      mem[32'h0001_0004] = 32'h0002_0007;
      mem[32'h0002_000C] = 32'h0055_5007;
      mem[32'h0001_000C] = 32'h0003_0023;
      mem[32'h0003_0018] = 32'h0077_7067;
      mem[32'h0001_0010] = 32'h0004_0025;
      mem[32'h0004_001C] = 32'h0088_8067;
      mem[32'h0001_0014] = 32'h0140_0087;

      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1 && mem_valid == 1'b0 && rsp_valid == 1'b0, "R10",
          "reset state", {29'h0, req_ready, mem_valid, rsp_valid}, 32'h4);
      rst_n = 1'b1;

      run("R1", 32'h0013_5678, 0, 0, 0, 0, 32'h0001_0000, 0, 32'hFFEF_FFFF);
      run("R1", 32'h0040_3123, 1, 1, 0, 1, 32'h0001_0000, 1, 32'hFFFF_FFFF);
      run("R5", 32'h0040_3123, 0, 0, 1, 0, 32'h0001_0000, 0, 32'hFFFF_FFFF);
      run("R7", 32'h0040_3123, 0, 0, 1, 0, 32'h0001_0000, 0, 32'hFFFF_FFFF);
      run("R7", 32'h0040_3123, 1, 0, 1, 0, 32'h0001_0000, 0, 32'hFFFF_FFFF);
      run("R3", 32'h0080_0000, 0, 1, 1, 0, 32'h0001_0000, 0, 32'hFFFF_FFFF);
      run("R3", 32'h0040_4000, 1, 1, 1, 0, 32'h0001_0000, 0, 32'hFFFF_FFFF);
      run("R6", 32'h00C0_6000, 0, 1, 1, 0, 32'h0001_0000, 0, 32'hFFFF_FFFF);
      run("R6", 32'h0100_7000, 1, 1, 1, 0, 32'h0001_0000, 0, 32'hFFFF_FFFF);
      run("R8", 32'h0100_7000, 1, 0, 1, 0, 32'h0001_0000, 0, 32'hFFFF_FFFF);
      run("R6", 32'h0100_7000, 1, 0, 1, 1, 32'h0001_0000, 0, 32'hFFFF_FFFF);
      run("R8", 32'h0100_7000, 0, 1, 1, 0, 32'h0001_0000, 0, 32'hFFFF_FFFF);
      run("R4", 32'h0152_3000, 1, 1, 1, 1, 32'h0001_0000, 1, 32'hFFFF_FFFF);
      run("R4", 32'h0152_3000, 0, 1, 1, 1, 32'h0001_0000, 1, 32'hFFFF_FFFF);
      run("R4", 32'h0152_3000, 0, 0, 1, 0, 32'h0001_0000, 0, 32'hFFFF_FFFF);
      run("R2", 32'h0040_3123, 0, 0, 1, 0, 32'h0011_0000, 0, 32'hFFEF_FFFF);

      repeat (3) @(negedge clk);
      chk(rsp_valid == 1'b0 && mem_valid == 1'b0, "R10", "quiet after last walk",
          {30'h0, rsp_valid, mem_valid}, 32'h0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule